// File: doc/BRIEF.md
# Floppy Controller Configuration Lock Unit

This block keeps the settings of a floppy disk controller that must survive a software reset. It stores the FIFO enable, the FIFO threshold, the track at which write precompensation begins, a lock bit and the two perpendicular-recording controls. The controls are named write-gate select and gap select here. A command sequencer upstream of this block has already decoded a command. It presents the command with a one-cycle valid strobe, an opcode and the argument fields.

Two reset sources reach the block. The hardware reset is synchronous and active-low. It always clears the lock and restores every default. The software reset is a one-cycle pulse raised by the host through the control or data-rate register. It returns the FIFO and precompensation settings to their defaults only while the lock bit is 0.

The block also does three more things:
- It produces one result byte after a lock command.
- It serves the bytes of a register dump through a combinational index.
- It decodes the two perpendicular controls into the gap 2 length that the disk formatter lays down, and into the part of that gap that a data write rewrites.

Top module: `fdc_cfg_lock`

## Requirements
- R1: While `rst_n` is low at a clock edge, that edge sets `lock_q`, `fifo_en`, `fifo_thr`, `pretrk`, `wgate`, `gap` and `res_valid` to 0.
- R2: When `sw_reset` is 1 at an edge and `lock_q` is 1, `fifo_en`, `fifo_thr` and `pretrk` keep their values.
- R3: When `sw_reset` is 1 at an edge and `lock_q` is 0, `fifo_en`, `fifo_thr` and `pretrk` return to 0 after that edge.
- R4: A software reset never changes `lock_q`, `wgate` or `gap`.
- R5: A command with `cmd_op` = 0 (configure) loads `cmd_fifo_en`, `cmd_fifo_thr` and `cmd_pretrk` at the edge where it is valid. This holds whatever the value of `lock_q`.
- R6: A command with `cmd_op` = 1 (lock) loads `cmd_lock` into `lock_q`. In the cycle after the command, `res_valid` is 1 for exactly one cycle. `res_byte` then has the new lock value in bit 4 and 0 in every other bit.
- R7: A command with `cmd_op` = 2 (perpendicular) loads `cmd_wgate` into `wgate` and `cmd_gap` into `gap`. Opcode 3 changes nothing.
- R8: `dump_byte` depends on `dump_sel`:
  - Index 0 gives `pretrk`.
  - Index 1 gives `fifo_thr` in bits 3:0 and `fifo_en` in bit 4.
  - Index 7 gives `lock_q` in bit 7, `wgate` in bit 1 and `gap` in bit 0, with the other bits 0.
  - Every other index gives 0.
- R9: The gap lengths depend on `wgate` and `gap`:

  | `wgate` | `gap` | `gap2_len` | `gap2_wr_len` |
  |---|---|---|---|
  | 0 | 0 | 22 | 0 |
  | 0 | 1 | 22 | 19 |
  | 1 | 0 | 22 | 0 |
  | 1 | 1 | 41 | 38 |

- R10: A command that is valid in the same cycle as `sw_reset` is discarded. It changes no setting and produces no result byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, synchronous, active-low |
| sw_reset | input | 1 | Software reset pulse from the control or data-rate register |
| cmd_valid | input | 1 | Decoded command strobe |
| cmd_op | input | 2 | 0 configure, 1 lock, 2 perpendicular, 3 none |
| cmd_fifo_en | input | 1 | Configure argument: FIFO enable |
| cmd_fifo_thr | input | 4 | Configure argument: FIFO threshold code |
| cmd_pretrk | input | 8 | Configure argument: precompensation start track |
| cmd_lock | input | 1 | Lock argument |
| cmd_wgate | input | 1 | Perpendicular argument: write-gate select |
| cmd_gap | input | 1 | Perpendicular argument: gap select |
| dump_sel | input | 4 | Dump byte index |
| fifo_en | output | 1 | FIFO enable setting |
| fifo_thr | output | 4 | FIFO threshold setting |
| pretrk | output | 8 | Precompensation start track |
| lock_q | output | 1 | Lock bit |
| wgate | output | 1 | Write-gate select |
| gap | output | 1 | Gap select |
| res_valid | output | 1 | Lock result byte valid |
| res_byte | output | 8 | Lock result byte |
| dump_byte | output | 8 | Selected dump byte |
| gap2_len | output | 8 | Gap 2 format length in bytes |
| gap2_wr_len | output | 8 | Bytes of gap 2 rewritten by a data write |

## Verification
The assertions take `sw_reset` to be a single-cycle pulse. They also take `cmd_op` and the argument fields to be defined whenever `cmd_valid` is 1. The result check relies on a lock command not being repeated in the cycle right after another one. The bench drives every input on the falling edge, from reset onward. It pulses the software reset for one cycle, and between commands it returns `cmd_valid` to 0 with `cmd_op` set to 3. It issues the collision case (R10) deliberately, to show that the software reset takes precedence.

// File: rtl/fdc_cfg_pkg.sv
// Package: shared opcode type and gap length constants for the
// configuration lock unit. Assumes an 8-bit byte-wide result path.
package fdc_cfg_pkg;

    typedef enum logic [1:0] {
        OP_CONFIGURE = 2'd0,
        OP_LOCK      = 2'd1,
        OP_PERP      = 2'd2,
        OP_NONE      = 2'd3
    } fdc_op_e;

    localparam int unsigned BYTE_W        = 8;
    localparam int unsigned GAP2_STD      = 22;
    localparam int unsigned GAP2_WIDE     = 41;
    localparam int unsigned GAP2_WR_500K  = 19;
    localparam int unsigned GAP2_WR_1M    = 38;
    localparam int unsigned LOCK_RES_BIT  = 4;
    localparam int unsigned DUMP_LOCK_IDX = 7;

endpackage

// File: rtl/fdc_cfg_regs.sv
// Module: fdc_cfg_regs
// Holds the guarded settings (FIFO enable, threshold, precompensation
// track), the lock bit and the perpendicular controls, and arbitrates
// between hardware reset, software reset and decoded commands.
// Assumes: sw_reset is a single-cycle pulse; a command coinciding with
// sw_reset is dropped; rst_n is synchronous and active-low.
module fdc_cfg_regs
    import fdc_cfg_pkg::*;
#(
    parameter int unsigned THR_W       = 4,
    parameter int unsigned TRK_W       = 8,
    parameter logic        DEF_FIFO_EN = 1'b0,
    parameter logic [THR_W-1:0] DEF_THR = '0,
    parameter logic [TRK_W-1:0] DEF_TRK = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_reset,
    input  logic             cmd_valid,
    input  fdc_op_e          cmd_op,
    input  logic             cmd_fifo_en,
    input  logic [THR_W-1:0] cmd_fifo_thr,
    input  logic [TRK_W-1:0] cmd_pretrk,
    input  logic             cmd_lock,
    input  logic             cmd_wgate,
    input  logic             cmd_gap,
    output logic             fifo_en,
    output logic [THR_W-1:0] fifo_thr,
    output logic [TRK_W-1:0] pretrk,
    output logic             lock_q,
    output logic             wgate,
    output logic             gap,
    output logic             lock_cmd_taken
);

    logic cmd_ok;
    logic do_cfg;
    logic do_lock;
    logic do_perp;
    logic restore_guarded;

    // Qualify a command: software reset in the same cycle wins.
    always_comb begin
        cmd_ok          = cmd_valid && !sw_reset;
        do_cfg          = cmd_ok && (cmd_op == OP_CONFIGURE);
        do_lock         = cmd_ok && (cmd_op == OP_LOCK);
        do_perp         = cmd_ok && (cmd_op == OP_PERP);
        restore_guarded = sw_reset && !lock_q;
    end

    // Guarded settings: restored by hardware reset or an unlocked soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n || restore_guarded) begin
            fifo_en  <= DEF_FIFO_EN;
            fifo_thr <= DEF_THR;
            pretrk   <= DEF_TRK;
        end else if (do_cfg) begin
            fifo_en  <= cmd_fifo_en;
            fifo_thr <= cmd_fifo_thr;
            pretrk   <= cmd_pretrk;
        end
    end

    // Lock bit: only hardware reset or a lock command changes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
        end else if (do_lock) begin
            lock_q <= cmd_lock;
        end
    end

    // Perpendicular controls: cleared by hardware reset only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wgate <= 1'b0;
            gap   <= 1'b0;
        end else if (do_perp) begin
            wgate <= cmd_wgate;
            gap   <= cmd_gap;
        end
    end

    assign lock_cmd_taken = do_lock;

endmodule

// File: rtl/fdc_cfg_result.sv
// Module: fdc_cfg_result
// Registers the one-cycle result byte that follows an accepted lock
// command. Assumes lock_taken is already qualified against soft reset.
module fdc_cfg_result
    import fdc_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_taken,
    input  logic              lock_value,
    output logic              res_valid,
    output logic [BYTE_W-1:0] res_byte
);

    logic [BYTE_W-1:0] res_next;

    // Place the lock value at its result bit, all other bits zero.
    always_comb begin
        res_next               = '0;
        res_next[LOCK_RES_BIT] = lock_value;
    end

    // Capture the result for one cycle after an accepted lock command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_byte  <= '0;
        end else begin
            res_valid <= lock_taken;
            res_byte  <= lock_taken ? res_next : '0;
        end
    end

endmodule

// File: rtl/fdc_cfg_dump.sv
// Module: fdc_cfg_dump
// Combinational register-dump byte selector. Assumes THR_W <= 7 and
// TRK_W <= 8 so each field fits its byte; unused indices read as zero.
module fdc_cfg_dump
    import fdc_cfg_pkg::*;
#(
    parameter int unsigned THR_W = 4,
    parameter int unsigned TRK_W = 8,
    parameter int unsigned SEL_W = 4
) (
    input  logic [SEL_W-1:0]  dump_sel,
    input  logic              fifo_en,
    input  logic [THR_W-1:0]  fifo_thr,
    input  logic [TRK_W-1:0]  pretrk,
    input  logic              lock_q,
    input  logic              wgate,
    input  logic              gap,
    output logic [BYTE_W-1:0] dump_byte
);

    logic [BYTE_W-1:0] byte_trk;
    logic [BYTE_W-1:0] byte_fifo;
    logic [BYTE_W-1:0] byte_lock;

    // Assemble the populated dump bytes from the live settings.
    always_comb begin
        byte_trk               = '0;
        byte_trk[TRK_W-1:0]    = pretrk;
        byte_fifo              = '0;
        byte_fifo[THR_W-1:0]   = fifo_thr;
        byte_fifo[THR_W]       = fifo_en;
        byte_lock              = '0;
        byte_lock[BYTE_W-1]    = lock_q;
        byte_lock[1]           = wgate;
        byte_lock[0]           = gap;
    end

    // Route the indexed byte to the output.
    always_comb begin
        if (dump_sel == SEL_W'(0)) begin
            dump_byte = byte_trk;
        end else if (dump_sel == SEL_W'(1)) begin
            dump_byte = byte_fifo;
        end else if (dump_sel == SEL_W'(DUMP_LOCK_IDX)) begin
            dump_byte = byte_lock;
        end else begin
            dump_byte = '0;
        end
    end

endmodule

// File: rtl/fdc_gap_decode.sv
// Module: fdc_gap_decode
// Decodes the perpendicular controls into gap 2 lengths for the
// formatter. Purely combinational; the reserved code acts as conventional.
module fdc_gap_decode
    import fdc_cfg_pkg::*;
(
    input  logic              wgate,
    input  logic              gap,
    output logic [BYTE_W-1:0] gap2_len,
    output logic [BYTE_W-1:0] gap2_wr_len
);

    // Map the two control bits onto the format and rewrite lengths.
    always_comb begin
        unique case ({wgate, gap})
            2'b01: begin
                gap2_len    = BYTE_W'(GAP2_STD);
                gap2_wr_len = BYTE_W'(GAP2_WR_500K);
            end
            2'b11: begin
                gap2_len    = BYTE_W'(GAP2_WIDE);
                gap2_wr_len = BYTE_W'(GAP2_WR_1M);
            end
            default: begin
                gap2_len    = BYTE_W'(GAP2_STD);
                gap2_wr_len = '0;
            end
        endcase
    end

endmodule

// File: rtl/fdc_cfg_lock.sv
// Module: fdc_cfg_lock (top)
// Configuration store of a floppy controller with a lock that shields the
// FIFO and precompensation settings from software reset. Assumes commands
// arrive already decoded, one per valid cycle.
module fdc_cfg_lock
    import fdc_cfg_pkg::*;
#(
    parameter int unsigned THR_W = 4,
    parameter int unsigned TRK_W = 8,
    parameter int unsigned SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_reset,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic             cmd_fifo_en,
    input  logic [THR_W-1:0] cmd_fifo_thr,
    input  logic [TRK_W-1:0] cmd_pretrk,
    input  logic             cmd_lock,
    input  logic             cmd_wgate,
    input  logic             cmd_gap,
    input  logic [SEL_W-1:0] dump_sel,
    output logic             fifo_en,
    output logic [THR_W-1:0] fifo_thr,
    output logic [TRK_W-1:0] pretrk,
    output logic             lock_q,
    output logic             wgate,
    output logic             gap,
    output logic             res_valid,
    output logic [7:0]       res_byte,
    output logic [7:0]       dump_byte,
    output logic [7:0]       gap2_len,
    output logic [7:0]       gap2_wr_len
);

    fdc_op_e op_e;
    logic    lock_taken;

    // Give the raw opcode its enumerated type.
    always_comb begin
        op_e = fdc_op_e'(cmd_op);
    end

    fdc_cfg_regs #(
        .THR_W (THR_W),
        .TRK_W (TRK_W)
    ) u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .sw_reset       (sw_reset),
        .cmd_valid      (cmd_valid),
        .cmd_op         (op_e),
        .cmd_fifo_en    (cmd_fifo_en),
        .cmd_fifo_thr   (cmd_fifo_thr),
        .cmd_pretrk     (cmd_pretrk),
        .cmd_lock       (cmd_lock),
        .cmd_wgate      (cmd_wgate),
        .cmd_gap        (cmd_gap),
        .fifo_en        (fifo_en),
        .fifo_thr       (fifo_thr),
        .pretrk         (pretrk),
        .lock_q         (lock_q),
        .wgate          (wgate),
        .gap            (gap),
        .lock_cmd_taken (lock_taken)
    );

    fdc_cfg_result u_result (
        .clk        (clk),
        .rst_n      (rst_n),
        .lock_taken (lock_taken),
        .lock_value (cmd_lock),
        .res_valid  (res_valid),
        .res_byte   (res_byte)
    );

    fdc_cfg_dump #(
        .THR_W (THR_W),
        .TRK_W (TRK_W),
        .SEL_W (SEL_W)
    ) u_dump (
        .dump_sel  (dump_sel),
        .fifo_en   (fifo_en),
        .fifo_thr  (fifo_thr),
        .pretrk    (pretrk),
        .lock_q    (lock_q),
        .wgate     (wgate),
        .gap       (gap),
        .dump_byte (dump_byte)
    );

    fdc_gap_decode u_gap (
        .wgate       (wgate),
        .gap         (gap),
        .gap2_len    (gap2_len),
        .gap2_wr_len (gap2_wr_len)
    );

endmodule

// File: rtl/fdc_cfg_lock_chk.sv
// Module: fdc_cfg_lock_chk
// Assertion checker bound to fdc_cfg_lock; observes ports only.
module fdc_cfg_lock_chk #(
    parameter int unsigned THR_W = 4,
    parameter int unsigned TRK_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sw_reset,
    input logic             cmd_valid,
    input logic [1:0]       cmd_op,
    input logic             cmd_lock,
    input logic             fifo_en,
    input logic [THR_W-1:0] fifo_thr,
    input logic [TRK_W-1:0] pretrk,
    input logic             lock_q,
    input logic             wgate,
    input logic             gap,
    input logic             res_valid,
    input logic [7:0]       res_byte,
    input logic [7:0]       gap2_len,
    input logic [7:0]       gap2_wr_len
);

    p_locked_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_reset && lock_q) |=> ($stable(fifo_en) && $stable(fifo_thr) && $stable(pretrk)));

    p_unlocked_restore_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_reset && !lock_q) |=> (!fifo_en && fifo_thr == '0 && pretrk == '0));

    p_swrst_keeps_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> ($stable(lock_q) && $stable(wgate) && $stable(gap)));

    p_lock_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd1 && !sw_reset)
        |=> (res_valid && res_byte == {3'b000, $past(cmd_lock), 4'b0000}));

    p_result_matches_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_byte[4] == lock_q && $countones(res_byte) <= 1));

    p_collide_no_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && sw_reset) |=> !res_valid);

    p_gap_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (gap2_wr_len < gap2_len) && (gap2_len == ((wgate && gap) ? 8'd41 : 8'd22)));

endmodule

bind fdc_cfg_lock fdc_cfg_lock_chk #(
    .THR_W (THR_W),
    .TRK_W (TRK_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_reset    (sw_reset),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_lock    (cmd_lock),
    .fifo_en     (fifo_en),
    .fifo_thr    (fifo_thr),
    .pretrk      (pretrk),
    .lock_q      (lock_q),
    .wgate       (wgate),
    .gap         (gap),
    .res_valid   (res_valid),
    .res_byte    (res_byte),
    .gap2_len    (gap2_len),
    .gap2_wr_len (gap2_wr_len)
);

// File: tb/fdc_cfg_lock_bench.sv
// Directed bench for fdc_cfg_lock: one task per scenario.
module fdc_cfg_lock_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sw_reset;
    logic       cmd_valid;
    logic [1:0] cmd_op;
    logic       cmd_fifo_en;
    logic [3:0] cmd_fifo_thr;
    logic [7:0] cmd_pretrk;
    logic       cmd_lock;
    logic       cmd_wgate;
    logic       cmd_gap;
    logic [3:0] dump_sel;
    logic       fifo_en;
    logic [3:0] fifo_thr;
    logic [7:0] pretrk;
    logic       lock_q;
    logic       wgate;
    logic       gap;
    logic       res_valid;
    logic [7:0] res_byte;
    logic [7:0] dump_byte;
    logic [7:0] gap2_len;
    logic [7:0] gap2_wr_len;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    fdc_cfg_lock u_fdc_cfg_lock (
        .clk (clk), .rst_n (rst_n), .sw_reset (sw_reset),
        .cmd_valid (cmd_valid), .cmd_op (cmd_op),
        .cmd_fifo_en (cmd_fifo_en), .cmd_fifo_thr (cmd_fifo_thr),
        .cmd_pretrk (cmd_pretrk), .cmd_lock (cmd_lock),
        .cmd_wgate (cmd_wgate), .cmd_gap (cmd_gap), .dump_sel (dump_sel),
        .fifo_en (fifo_en), .fifo_thr (fifo_thr), .pretrk (pretrk),
        .lock_q (lock_q), .wgate (wgate), .gap (gap),
        .res_valid (res_valid), .res_byte (res_byte), .dump_byte (dump_byte),
        .gap2_len (gap2_len), .gap2_wr_len (gap2_wr_len)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            finish_run();
        end
    end

    task automatic idle_inputs();
        sw_reset  = 1'b0;
        cmd_valid = 1'b0;
        cmd_op    = 2'd3;
    endtask

    // Drive one command on a falling edge; settings are visible after the next rising edge.
    task automatic issue(input logic [1:0] op, input logic fe, input logic [3:0] thr,
                         input logic [7:0] trk, input logic lk, input logic wg, input logic gp);
        cmd_valid    = 1'b1;
        cmd_op       = op;
        cmd_fifo_en  = fe;
        cmd_fifo_thr = thr;
        cmd_pretrk   = trk;
        cmd_lock     = lk;
        cmd_wgate    = wg;
        cmd_gap      = gp;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic soft_reset();
        sw_reset = 1'b1;
        @(negedge clk);
        sw_reset = 1'b0;
    endtask

    task automatic t_hw_reset();
        rst_n = 1'b0;
        idle_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 lock", lock_q, 0);
        chk("R1 fifo_en", fifo_en, 0);
        chk("R1 thr", fifo_thr, 0);
        chk("R1 pretrk", pretrk, 0);
        chk("R1 wgate/gap", {wgate, gap}, 0);
        chk("R1 res_valid", res_valid, 0);
    endtask

    task automatic t_configure();
        issue(2'd0, 1'b1, 4'd9, 8'd37, 1'b0, 1'b0, 1'b0);
        chk("R5 fifo_en", fifo_en, 1);
        chk("R5 thr", fifo_thr, 9);
        chk("R5 pretrk", pretrk, 37);
    endtask

    task automatic t_soft_unlocked();
        soft_reset();
        chk("R3 fifo_en", fifo_en, 0);
        chk("R3 thr", fifo_thr, 0);
        chk("R3 pretrk", pretrk, 0);
        chk("R4 lock unchanged", lock_q, 0);
    endtask

    task automatic t_lock_cmd(input logic lk);
        issue(2'd1, 1'b0, 4'd0, 8'd0, lk, 1'b0, 1'b0);
        chk("R6 res_valid", res_valid, 1);
        chk("R6 res_byte", res_byte, lk ? 16 : 0);
        chk("R6 lock_q", lock_q, lk);
        @(negedge clk);
        chk("R6 res_valid one cycle", res_valid, 0);
    endtask

    task automatic t_soft_locked();
        issue(2'd0, 1'b1, 4'd15, 8'd200, 1'b0, 1'b0, 1'b0);
        chk("R5 configure while locked", pretrk, 200);
        soft_reset();
        chk("R2 fifo_en kept", fifo_en, 1);
        chk("R2 thr kept", fifo_thr, 15);
        chk("R2 pretrk kept", pretrk, 200);
        chk("R4 lock kept", lock_q, 1);
    endtask

    task automatic t_perp_and_gap();
        for (int k = 0; k < 4; k++) begin
            issue(2'd2, 1'b0, 4'd0, 8'd0, 1'b0, k[1], k[0]);
            chk("R7 wgate/gap", {wgate, gap}, k);
            chk("R9 gap2_len", gap2_len, (k == 3) ? 41 : 22);
            chk("R9 gap2_wr_len", gap2_wr_len, (k == 3) ? 38 : ((k == 1) ? 19 : 0));
        end
        soft_reset();
        chk("R4 perp kept", {wgate, gap}, 3);
        issue(2'd3, 1'b0, 4'd1, 8'd1, 1'b0, 1'b0, 1'b0);
        chk("R7 opcode 3 no effect", {wgate, gap, lock_q}, 7);
    endtask

    task automatic t_dump();
        for (int i = 0; i < 16; i++) begin
            dump_sel = 4'(i);
            #1;
            if (i == 0)      chk("R8 dump 0", dump_byte, 200);
            else if (i == 1) chk("R8 dump 1", dump_byte, 8'h1F);
            else if (i == 7) chk("R8 dump 7", dump_byte, 8'h83);
            else             chk("R8 dump other", dump_byte, 0);
        end
        @(negedge clk);
    endtask

    task automatic t_collide();
        cmd_valid = 1'b1;
        cmd_op = 2'd1;
        cmd_lock = 1'b0;
        sw_reset = 1'b1;
        @(negedge clk);
        idle_inputs();
        chk("R10 lock not taken", lock_q, 1);
        chk("R10 no result", res_valid, 0);
        chk("R10 locked settings kept", pretrk, 200);
        cmd_valid = 1'b1;
        cmd_op = 2'd0;
        cmd_pretrk = 8'd5;
        sw_reset = 1'b1;
        @(negedge clk);
        idle_inputs();
        chk("R10 configure dropped", pretrk, 200);
    endtask

    task automatic t_hw_clears_lock();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 lock cleared", lock_q, 0);
        chk("R1 pretrk default", pretrk, 0);
        chk("R1 perp cleared", {wgate, gap}, 0);
    endtask

    initial begin
        rst_n = 1'b0;
        idle_inputs();
        cmd_fifo_en = 1'b0; cmd_fifo_thr = '0; cmd_pretrk = '0;
        cmd_lock = 1'b0; cmd_wgate = 1'b0; cmd_gap = 1'b0;
        dump_sel = '0;
        @(negedge clk);
        t_hw_reset();
        t_configure();
        t_soft_unlocked();
        t_lock_cmd(1'b1);
        t_soft_locked();
        t_perp_and_gap();
        t_dump();
        t_collide();
        t_lock_cmd(1'b0);
        t_lock_cmd(1'b1);
        t_hw_clears_lock();
        done = 1'b1;
        finish_run();
    end

endmodule